// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers a large set of level-sensitive interrupt sources, arranged as 32 groups of 8 lines each. Each group drives one output line toward the main interrupt controller. A group line goes high when at least one of its sources is both pending and enabled. Software manages the block through a small word-addressed register port. The port does one access per cycle: writes take effect at the clock edge, and reads are combinational on the presented address.

Four groups share each 32-bit register bank. Every bank offers an enable-set word, an enable-clear word, a raw level word and a masked level word. A summary word shows, with one bit per group, which groups currently have a masked source pending. Selected groups, set by a parameter, are reserved and have no sources wired. By default these are groups 12 and 14. A reserved group reads as zero, keeps none of the enables written to it, and never raises its line.

Top module: `grp_irq_combiner`

## Requirements
- R1: Source s of group g is bit (g mod 4)*8+s of bank g/4, and it is input bit g*8+s of `src_lvl`. Bank n occupies byte addresses 0x10*n to 0x10*n+0xF. Within a bank, word offset 0x0 is enable-set, 0x4 is enable-clear, 0x8 is raw level and 0xC is masked level. Address bits [1:0] are ignored.
- R2: Writing the enable-set word turns on every enable whose data bit is 1 and leaves every enable whose data bit is 0 unchanged. Reading either the set word or the clear word returns the current enables of that bank.
- R3: Writing the enable-clear word turns off every enable whose data bit is 1 and leaves every enable whose data bit is 0 unchanged.
- R4: The raw level word returns the present level of each source input, whether or not that source is enabled.
- R5: The masked level word returns the raw level word ANDed with the bank's enables.
- R6: Output `grp_irq[g]` is the OR of the eight masked bits of group g, taken from a register. A change at the inputs or at the enables shows up one clock edge later.
- R7: The word at address 0x100 returns the same registered per-group summary, with bit g for group g, that drives `grp_irq`.
- R8: Groups marked in `RESV_GROUPS` (groups 12 and 14 by default) read as zero in every word, ignore enable writes, and never assert their output.
- R9: Reset clears every enable, so all outputs and all summary bits are low after reset.
- R10: Writes to the raw, masked or summary words, and to unmapped addresses, change no state. Reads from unmapped addresses (0x80 to 0xFF, and anything above 0x100) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 256 | Level inputs from the sources, group g at bits g*8+7..g*8 |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wen | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| grp_irq | output | 32 | Registered per-group interrupt lines |

## Verification
Several properties are checked on every cycle:
- A set write leaves every written 1 enabled.
- A clear write leaves every written 1 disabled.
- A bank that no write selected keeps its enables.
- Reserved groups hold no enable and never raise a line.
- The summary word always equals the output lines.
- The masked word never shows a bit that the raw word lacks.
- Unmapped reads return zero.

Other properties only the directed scenarios can show. These are the exact bit placement of each group within its bank and the one-edge delay from an input to its line. They also include the reset state, and the fact that writes to read-only words leave the enables untouched. The scenarios compare these against values the bench computes on its own.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

  // Word slot inside a register bank, decoded from address bits [3:2]
  typedef enum logic [1:0] {
    SLOT_EN_SET = 2'd0,
    SLOT_EN_CLR = 2'd1,
    SLOT_RAW    = 2'd2,
    SLOT_MSK    = 2'd3
  } slot_e;

  localparam int unsigned BANK_BYTES = 16;

  // Flat bit index of source s within group g
  function automatic int unsigned flat_bit(int unsigned g, int unsigned s, int unsigned srcw);
    return g * srcw + s;
  endfunction

  // Bank that holds group g
  function automatic int unsigned bank_of(int unsigned g, int unsigned gpb);
    return g / gpb;
  endfunction

endpackage

// File: rtl/cmb_addr_decode.sv
module cmb_addr_decode
  import cmb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANKS     = 8,
  parameter int unsigned COMB_ADDR = 256,
  localparam int unsigned BIDX_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_bank,
  output logic              hit_comb,
  output logic [BIDX_W-1:0] bank_idx,
  output slot_e             slot
);

  localparam int unsigned SHIFT = $clog2(BANK_BYTES);

  logic [ADDR_W-1:0] word_addr;
  logic [ADDR_W-1:0] bank_num;

  always_comb begin
    word_addr = {addr[ADDR_W-1:2], 2'b00};
    bank_num  = word_addr >> SHIFT;
    hit_bank  = bank_num < ADDR_W'(BANKS);
    hit_comb  = word_addr == ADDR_W'(COMB_ADDR);
    bank_idx  = BIDX_W'(bank_num);
    slot      = slot_e'(addr[3:2]);
  end

endmodule

// File: rtl/cmb_enable_bank.sv
module cmb_enable_bank #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);

  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] en_d;

  always_comb begin
    set_bits = wdata & VALID;
    en_d     = en_q;
    if (set_we) en_d = en_q | set_bits;
    else if (clr_we) en_d = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & $past(wdata & VALID)) == $past(wdata & VALID))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((en_q & $past(wdata)) == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en_q)); // R10
  AST_RESV_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~VALID) == '0); // R8

endmodule

// File: rtl/cmb_group_reduce.sv
module cmb_group_reduce #(
  parameter int unsigned GROUPS = 32,
  parameter int unsigned SRC_W  = 8,
  parameter logic [GROUPS-1:0] RESV = '0,
  localparam int unsigned NSRC  = GROUPS * SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   masked,
  output logic [GROUPS-1:0] grp_q
);

  logic [GROUPS-1:0] grp_any;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    if (RESV[g]) begin : g_resv
      assign grp_any[g] = 1'b0;
    end else begin : g_live
      assign grp_any[g] = |masked[g*SRC_W +: SRC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= '0;
    else        grp_q <= grp_any;
  end

  AST_RESV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_q & RESV) == '0); // R8

endmodule

// File: rtl/cmb_read_mux.sv
module cmb_read_mux
  import cmb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BANKS  = 8,
  parameter int unsigned GROUPS = 32,
  localparam int unsigned NSRC  = DATA_W * BANKS,
  localparam int unsigned BIDX_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_bank,
  input  logic              hit_comb,
  input  logic [BIDX_W-1:0] bank_idx,
  input  slot_e             slot,
  input  logic [NSRC-1:0]   en_all,
  input  logic [NSRC-1:0]   raw_all,
  input  logic [GROUPS-1:0] grp_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] en_word;
  logic [DATA_W-1:0] raw_word;

  always_comb begin
    en_word  = en_all[bank_idx*DATA_W +: DATA_W];
    raw_word = raw_all[bank_idx*DATA_W +: DATA_W];
    rdata    = '0;
    if (hit_bank) begin
      unique case (slot)
        SLOT_EN_SET, SLOT_EN_CLR: rdata = en_word;
        SLOT_RAW:                 rdata = raw_word;
        SLOT_MSK:                 rdata = raw_word & en_word;
        default:                  rdata = '0;
      endcase
    end else if (hit_comb) begin
      rdata = DATA_W'(grp_q);
    end
  end

  AST_MSK_WITHIN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_bank && slot == SLOT_MSK) |-> ((rdata & ~raw_word) == '0)); // R5

endmodule

// File: rtl/grp_irq_combiner.sv
module grp_irq_combiner
  import cmb_pkg::*;
#(
  parameter int unsigned GROUPS       = 32,
  parameter int unsigned SRC_W        = 8,
  parameter int unsigned GRP_PER_BANK = 4,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned COMB_ADDR    = 256,
  parameter logic [31:0] RESV_GROUPS  = 32'h0000_5000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [GROUPS*SRC_W-1:0]    src_lvl,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic                       reg_wen,
  input  logic [SRC_W*GRP_PER_BANK-1:0] reg_wdata,
  output logic [SRC_W*GRP_PER_BANK-1:0] reg_rdata,
  output logic [GROUPS-1:0]          grp_irq
);

  localparam int unsigned DATA_W = SRC_W * GRP_PER_BANK;
  localparam int unsigned BANKS  = GROUPS / GRP_PER_BANK;
  localparam int unsigned NSRC   = GROUPS * SRC_W;
  localparam int unsigned BIDX_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam logic [GROUPS-1:0] RESV = GROUPS'(RESV_GROUPS);

  // Bits of bank b that belong to live groups
  function automatic logic [DATA_W-1:0] bank_keep(int unsigned b);
    logic [DATA_W-1:0] k;
    k = '0;
    for (int unsigned j = 0; j < GRP_PER_BANK; j++) begin
      if (!RESV[b*GRP_PER_BANK + j]) k[j*SRC_W +: SRC_W] = '1;
    end
    return k;
  endfunction

  logic              hit_bank;
  logic              hit_comb;
  logic [BIDX_W-1:0] bank_idx;
  slot_e             slot;
  logic [NSRC-1:0]   en_all;
  logic [NSRC-1:0]   keep_all;
  logic [NSRC-1:0]   raw_all;
  logic [NSRC-1:0]   masked_all;
  logic [GROUPS-1:0] grp_q;

  cmb_addr_decode #(
    .ADDR_W(ADDR_W), .BANKS(BANKS), .COMB_ADDR(COMB_ADDR)
  ) u_dec (
    .addr(reg_addr), .hit_bank(hit_bank), .hit_comb(hit_comb),
    .bank_idx(bank_idx), .slot(slot)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [DATA_W-1:0] KEEP = bank_keep(b);
    logic set_we;
    logic clr_we;
    assign set_we = reg_wen && hit_bank && (bank_idx == BIDX_W'(b)) && (slot == SLOT_EN_SET);
    assign clr_we = reg_wen && hit_bank && (bank_idx == BIDX_W'(b)) && (slot == SLOT_EN_CLR);
    assign keep_all[b*DATA_W +: DATA_W] = KEEP;

    cmb_enable_bank #(.DATA_W(DATA_W), .VALID(KEEP)) u_en (
      .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
      .wdata(reg_wdata), .en_q(en_all[b*DATA_W +: DATA_W])
    );
  end

  assign raw_all    = src_lvl & keep_all;
  assign masked_all = raw_all & en_all;

  cmb_group_reduce #(.GROUPS(GROUPS), .SRC_W(SRC_W), .RESV(RESV)) u_red (
    .clk(clk), .rst_n(rst_n), .masked(masked_all), .grp_q(grp_q)
  );

  cmb_read_mux #(.DATA_W(DATA_W), .BANKS(BANKS), .GROUPS(GROUPS)) u_rd (
    .clk(clk), .rst_n(rst_n), .hit_bank(hit_bank), .hit_comb(hit_comb),
    .bank_idx(bank_idx), .slot(slot), .en_all(en_all), .raw_all(raw_all),
    .grp_q(grp_q), .rdata(reg_rdata)
  );

  assign grp_irq = grp_q;

  AST_SUMMARY_IS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_comb |-> (reg_rdata == DATA_W'(grp_irq))); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_bank && !hit_comb) |-> (reg_rdata == '0)); // R10
  AST_RESV_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_irq & RESV) == '0); // R8

endmodule

// File: tb/sim_grp_irq_combiner.sv
module sim_grp_irq_combiner;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] src = '0;
  logic [11:0]  addr = '0;
  logic         wen = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [31:0]  grp_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  grp_irq_combiner u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src), .reg_addr(addr),
    .reg_wen(wen), .reg_wdata(wdata), .reg_rdata(rdata), .grp_irq(grp_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int n = 0; n < 8; n++) begin
      rd(12'(16*n), d);
      check("R9 enables cleared", d, 32'h0);
    end
    check("R9 lines low", grp_irq, 32'h0);
    rd(12'h100, d);
    check("R9 summary low", d, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    wr(12'h010, 32'h0000_00A5);
    rd(12'h010, d); check("R2 set word", d, 32'h0000_00A5);
    rd(12'h014, d); check("R2 clr addr reads enables", d, 32'h0000_00A5);
    wr(12'h010, 32'h0000_FF00);
    rd(12'h010, d); check("R2 zeros keep enables", d, 32'h0000_FFA5);
    wr(12'h014, 32'h0000_0081);
    rd(12'h010, d); check("R3 clear ones", d, 32'h0000_FF24);
    wr(12'h014, 32'h0);
    rd(12'h010, d); check("R3 zero clear no effect", d, 32'h0000_FF24);
    rd(12'h000, d); check("R1 other bank untouched", d, 32'h0);
    wr(12'h014, 32'hFFFF_FFFF);
  endtask

  task automatic t_raw_masked();
    logic [31:0] d;
    @(negedge clk);
    src[64 +: 32] = 32'hDEAD_BEEF;
    rd(12'h028, d); check("R4 raw ignores enable", d, 32'hDEAD_BEEF);
    wr(12'h020, 32'h0F0F_00FF);
    rd(12'h028, d); check("R4 raw after enable", d, 32'hDEAD_BEEF);
    rd(12'h02C, d); check("R5 masked", d, 32'h0E0D_00EF);
    rd(12'h02B, d); check("R1 low addr bits ignored", d, 32'hDEAD_BEEF);
    wr(12'h024, 32'hFFFF_FFFF);
    @(negedge clk);
    src = '0;
  endtask

  task automatic t_outputs();
    logic [31:0] d;
    wr(12'h010, 32'h0000_0800);   // group 5, source 3
    wr(12'h070, 32'h8000_0000);   // group 31, source 7
    @(negedge clk);
    check("R6 idle lines", grp_irq, 32'h0);
    src[5*8+3] = 1'b1;
    src[6*8]   = 1'b1;            // group 6 not enabled
    #1;
    check("R6 not before edge", grp_irq, 32'h0);
    @(negedge clk);
    check("R6 line one edge later", grp_irq, 32'h0000_0020);
    rd(12'h100, d); check("R7 summary", d, 32'h0000_0020);
    src[255] = 1'b1;
    @(negedge clk);
    check("R1 last group line", grp_irq, 32'h8000_0020);
    wr(12'h014, 32'h0000_0800);
    check("R6 line after disable write", grp_irq, 32'h8000_0020);
    @(negedge clk);
    check("R6 line drops", grp_irq, 32'h8000_0000);
    rd(12'h100, d); check("R7 summary after drop", d, 32'h8000_0000);
    wr(12'h074, 32'hFFFF_FFFF);
    @(negedge clk);
    src = '0;
    @(negedge clk);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    @(negedge clk);
    src = '1;
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h030, d); check("R8 enables skip reserved", d, 32'hFF00_FF00);
    rd(12'h038, d); check("R8 raw reserved zero", d, 32'hFF00_FF00);
    rd(12'h03C, d); check("R8 masked reserved zero", d, 32'hFF00_FF00);
    @(negedge clk);
    check("R8 reserved lines low", grp_irq, 32'h0000_A000);
    rd(12'h100, d); check("R8 summary reserved low", d, 32'h0000_A000);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(12'h038, 32'hFFFF_FFFF);
    wr(12'h03C, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h0F4, 32'hFFFF_FFFF);
    rd(12'h030, d); check("R10 enables kept", d, 32'hFF00_FF00);
    rd(12'h000, d); check("R10 bank0 untouched", d, 32'h0);
    rd(12'h070, d); check("R10 bank7 untouched", d, 32'h0);
    @(negedge clk);
    check("R10 lines kept", grp_irq, 32'h0000_A000);
    rd(12'h080, d); check("R10 unmapped 0x80", d, 32'h0);
    rd(12'h104, d); check("R10 unmapped 0x104", d, 32'h0);
    rd(12'hFFC, d); check("R10 unmapped 0xFFC", d, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_raw_masked();
    t_outputs();
    t_reserved();
    t_readonly();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule